// File: doc/BRIEF.md
# Clock Control Register with Per-Field Write Guards

This block holds an 8-bit clock-control register on a simple register bus. The bus has a select, a write strobe and write data, and it returns read data. Each field of the register is written under its own rule. That rule depends on three live status inputs: self-clock mode is active, the PLL is the system clock, and the chip is in special mode. The block turns the stored value into enables for the clock monitor, the PLL, the frequency-modulation setting, fast wake-up, the real-time timer and the watchdog during pseudo stop, and self-clock mode.

The self-clock-mode enable is the sensitive field. In normal mode it can be written only once after reset. In special mode it can be written freely. While self-clock mode is running, it can never be cleared. A blocked field never stops the other fields of the same write from updating. Read-back always shows the stored bits, even when an output is overridden by status.

Top module: `clkctl_reg`

## Requirements
- R1: After reset the stored value is 0xF1.
- R2: With `sel` high, `rdata` returns the stored value. The layout is: bit 7 monitor enable, bit 6 PLL on, bits 5:4 modulation select, bit 3 fast wake-up, bit 2 timer run in pseudo stop, bit 1 watchdog run in pseudo stop, bit 0 self-clock-mode enable. With `sel` low, `rdata` is 0.
- R3: Bit 7 takes the write data only while `scm_active` is low. Otherwise it keeps its value.
- R4: Bits 6:4 take the write data only while `pll_is_sys` is low. Otherwise they keep their value.
- R5: `pll_on` is bit 6 ORed with `scm_active`. Read-back of bit 6 still shows the last value written.
- R6: In normal mode (`special_mode` low), bit 0 can be written only by the first write access after reset. That first write arms a lock whatever its data, and only reset clears the lock.
- R7: In special mode, bit 0 takes the write data on any write, whether or not the lock is armed.
- R8: While `scm_active` is high, a write never clears bit 0, in either mode.
- R9: Bits 3:1 take the write data on every write.
- R10: `fast_wake_en` is bit 3 ANDed with bit 0.
- R11: A write whose data would change a blocked field still updates the fields that are not blocked.
- R12: The register changes only on a clock edge where both `sel` and `wr_en` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, used together with sel |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0 when sel is low |
| scm_active | input | 1 | Self-clock mode is running |
| pll_is_sys | input | 1 | PLL drives the system clock |
| special_mode | input | 1 | Chip is in special mode |
| mon_en | output | 1 | Clock monitor enable |
| pll_on | output | 1 | PLL enable, forced on in self-clock mode |
| fm_sel | output | 2 | Frequency-modulation select |
| fast_wake_en | output | 1 | Effective fast wake-up enable |
| rti_pstop_en | output | 1 | Real-time timer runs in pseudo stop |
| wdog_pstop_en | output | 1 | Watchdog runs in pseudo stop |
| scm_en | output | 1 | Self-clock-mode enable |

## Verification
The bench aims at these corner cases:

- **Lock armed by a clearing write.** The first write after reset clears bit 0, and a later write in normal mode tries to set it again. A lock that armed only on a set would let that second write through.
- **Special mode with self-clock mode running.** A write of 0 to bit 0 must leave it set. A design that handled special mode as fully open would clear it.
- **Forced PLL output.** Reading bit 6 must show the written value while the output shows the forced one. A design that mixed status into the stored bit would fail both checks.
- **Mixed blocked and open writes.** Random writes hit guarded and free fields together. A design that dropped the whole write when any field was blocked would miss the updates to the free bits.

// File: rtl/clkctl_pkg.sv
// Package: field positions and widths shared by the clock-control register.
// Assumes one register of fixed layout; the modulation field width is a
// parameter, and every other position is derived from it.
package clkctl_pkg;
    parameter int FM_W     = 2;
    localparam int CTL_W   = FM_W + 6;
    localparam int B_SCME  = 0;
    localparam int B_WDOG  = 1;
    localparam int B_RTI   = 2;
    localparam int B_FWK   = 3;
    localparam int B_FM_LO = 4;
    localparam int B_FM_HI = B_FM_LO + FM_W - 1;
    localparam int B_PLL   = B_FM_HI + 1;
    localparam int B_MON   = B_PLL + 1;
endpackage

// File: rtl/clkctl_guard.sv
// Module: clkctl_guard
// Computes a per-bit write mask from live status and write data.
// Assumes the caller qualifies the mask with the bus write strobe.
module clkctl_guard
    import clkctl_pkg::*;
(
    input  logic             scm_active,
    input  logic             pll_is_sys,
    input  logic             special_mode,
    input  logic             once_armed,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] wmask
);
    logic scme_ok;

    // Bit 0 may be written if the mode allows it and the write is not a clear during self-clock mode.
    always_comb scme_ok = (special_mode || !once_armed) && !(scm_active && !wdata[B_SCME]);

    for (genvar b = 0; b < CTL_W; b++) begin : g_bit
        if (b == B_MON) begin : g_mon
            // Monitor enable is frozen while self-clock mode runs.
            always_comb wmask[b] = !scm_active;
        end else if (b >= B_FM_LO && b <= B_PLL) begin : g_pll
            // PLL on and modulation bits are frozen while the PLL is the system clock.
            always_comb wmask[b] = !pll_is_sys;
        end else if (b == B_SCME) begin : g_scme
            // Self-clock-mode enable follows its write-once and no-clear rules.
            always_comb wmask[b] = scme_ok;
        end else begin : g_free
            // Remaining bits are always writable.
            always_comb wmask[b] = 1'b1;
        end
    end
endmodule

// File: rtl/clkctl_store.sv
// Module: clkctl_store
// Holds the control value and the write-once lock.
// Assumes a synchronous active-low reset.
module clkctl_store
    import clkctl_pkg::*;
#(
    parameter logic [CTL_W-1:0] RST_VAL = 8'hF1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic [CTL_W-1:0] wmask,
    output logic [CTL_W-1:0] q,
    output logic             once_armed
);
    // Merge the permitted bits of a write into the stored value.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (wr) q <= (q & ~wmask) | (wdata & wmask);
    end

    // Arm the write-once lock on any write access; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)  once_armed <= 1'b0;
        else if (wr) once_armed <= 1'b1;
    end
endmodule

// File: rtl/clkctl_decode.sv
// Module: clkctl_decode
// Turns the stored value and live status into enables and read data.
// Purely combinational; assumes q is the registered value.
module clkctl_decode
    import clkctl_pkg::*;
(
    input  logic             sel,
    input  logic             scm_active,
    input  logic [CTL_W-1:0] q,
    output logic [CTL_W-1:0] rdata,
    output logic             mon_en,
    output logic             pll_on,
    output logic [FM_W-1:0]  fm_sel,
    output logic             fast_wake_en,
    output logic             rti_pstop_en,
    output logic             wdog_pstop_en,
    output logic             scm_en
);
    // Read data shows the stored bits when selected.
    always_comb rdata = sel ? q : '0;

    // Decode the enables; the PLL is forced on in self-clock mode.
    always_comb begin
        mon_en        = q[B_MON];
        pll_on        = q[B_PLL] | scm_active;
        fm_sel        = q[B_FM_HI:B_FM_LO];
        fast_wake_en  = q[B_FWK] & q[B_SCME];
        rti_pstop_en  = q[B_RTI];
        wdog_pstop_en = q[B_WDOG];
        scm_en        = q[B_SCME];
    end
endmodule

// File: rtl/clkctl_reg.sv
// Module: clkctl_reg (top)
// Clock-control register with per-field write guards and decoded enables.
// Assumes single-cycle bus writes qualified by sel and wr_en.
module clkctl_reg
    import clkctl_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'hF1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       scm_active,
    input  logic       pll_is_sys,
    input  logic       special_mode,
    output logic       mon_en,
    output logic       pll_on,
    output logic [1:0] fm_sel,
    output logic       fast_wake_en,
    output logic       rti_pstop_en,
    output logic       wdog_pstop_en,
    output logic       scm_en
);
    logic [CTL_W-1:0] ctl_q;
    logic [CTL_W-1:0] wmask;
    logic             once_armed;
    logic             wr;

    // A bus write needs both select and strobe.
    always_comb wr = sel && wr_en;

    clkctl_guard i_guard (
        .scm_active  (scm_active),
        .pll_is_sys  (pll_is_sys),
        .special_mode(special_mode),
        .once_armed  (once_armed),
        .wdata       (wdata),
        .wmask       (wmask)
    );

    clkctl_store #(.RST_VAL(RST_VAL)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .wdata     (wdata),
        .wmask     (wmask),
        .q         (ctl_q),
        .once_armed(once_armed)
    );

    clkctl_decode i_decode (
        .sel          (sel),
        .scm_active   (scm_active),
        .q            (ctl_q),
        .rdata        (rdata),
        .mon_en       (mon_en),
        .pll_on       (pll_on),
        .fm_sel       (fm_sel),
        .fast_wake_en (fast_wake_en),
        .rti_pstop_en (rti_pstop_en),
        .wdog_pstop_en(wdog_pstop_en),
        .scm_en       (scm_en)
    );
endmodule

// File: rtl/clkctl_chk.sv
// Module: clkctl_chk
// Checker bound to clkctl_reg; tracks its own write-once state.
module clkctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       wr_en,
    input logic       scm_active,
    input logic       pll_is_sys,
    input logic       special_mode,
    input logic [7:0] ctl_q,
    input logic       pll_on,
    input logic       fast_wake_en,
    input logic       scm_en
);
    logic seen_wr;

    // Record whether a write access happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              seen_wr <= 1'b0;
        else if (sel && wr_en)   seen_wr <= 1'b1;
    end

    a_r3_mon_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        scm_active |=> ctl_q[7] == $past(ctl_q[7]));
    a_r4_pll_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        pll_is_sys |=> ctl_q[6:4] == $past(ctl_q[6:4]));
    a_r5_pll_forced: assert property (@(posedge clk) disable iff (!rst_n)
        scm_active |-> pll_on);
    a_r6_once_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_wr && !special_mode) |=> ctl_q[0] == $past(ctl_q[0]));
    a_r8_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (scm_active && ctl_q[0]) |=> ctl_q[0]);
    a_r10_fwk_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !scm_en |-> !fast_wake_en);
    a_r12_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr_en) |=> $stable(ctl_q));
endmodule

bind clkctl_reg clkctl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .wr_en       (wr_en),
    .scm_active  (scm_active),
    .pll_is_sys  (pll_is_sys),
    .special_mode(special_mode),
    .ctl_q       (ctl_q),
    .pll_on      (pll_on),
    .fast_wake_en(fast_wake_en),
    .scm_en      (scm_en)
);

// File: tb/test_clkctl_reg.sv
module test_clkctl_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       scm_active = 1'b0, pll_is_sys = 1'b0, special_mode = 1'b0;
    logic [7:0] rdata;
    logic       mon_en, pll_on, fast_wake_en, rti_pstop_en, wdog_pstop_en, scm_en;
    logic [1:0] fm_sel;

    int         errors = 0;
    int         checks = 0;
    logic [7:0] m_q;
    logic       m_armed;

    always #5 clk = ~clk;

    clkctl_reg i_clkctl_reg (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .scm_active(scm_active), .pll_is_sys(pll_is_sys),
        .special_mode(special_mode), .mon_en(mon_en), .pll_on(pll_on),
        .fm_sel(fm_sel), .fast_wake_en(fast_wake_en), .rti_pstop_en(rti_pstop_en),
        .wdog_pstop_en(wdog_pstop_en), .scm_en(scm_en)
    );

    // Expected next stored value under the requirement rules.
    function automatic logic [7:0] f_next(logic [7:0] q, logic [7:0] d, logic scm,
                                          logic pll, logic spec, logic armed);
        logic [7:0] r = q;
        if (!scm) r[7] = d[7];                                 // R3
        if (!pll) r[6:4] = d[6:4];                             // R4
        r[3:1] = d[3:1];                                       // R9
        if ((spec || !armed) && !(scm && !d[0])) r[0] = d[0];  // R6 R7 R8
        return r;
    endfunction

    task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        chk(rdata, sel ? m_q : 8'h00, tag);
        chk({7'd0, mon_en}, {7'd0, m_q[7]}, "R3 mon_en");
        chk({7'd0, pll_on}, {7'd0, m_q[6] | scm_active}, "R5 pll_on");
        chk({6'd0, fm_sel}, {6'd0, m_q[5:4]}, "R4 fm_sel");
        chk({7'd0, fast_wake_en}, {7'd0, m_q[3] & m_q[0]}, "R10 fast_wake_en");
        chk({6'd0, rti_pstop_en, wdog_pstop_en}, {6'd0, m_q[2:1]}, "R9 pstop");
        chk({7'd0, scm_en}, {7'd0, m_q[0]}, "R6 scm_en");
    endtask

    // One bus cycle: drive at the falling edge, update model at the rising edge, check after it.
    task automatic cyc(logic s, logic w, logic [7:0] d, logic scm, logic pll,
                       logic spec, string tag);
        @(negedge clk);
        sel = s; wr_en = w; wdata = d;
        scm_active = scm; pll_is_sys = pll; special_mode = spec;
        @(posedge clk);
        if (s && w) begin
            m_q = f_next(m_q, d, scm, pll, spec, m_armed);
            m_armed = 1'b1;
        end
        #1;
        check_outputs(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sel = 1'b1; wr_en = 1'b0;
        scm_active = 1'b0; pll_is_sys = 1'b0; special_mode = 1'b0;
        repeat (2) @(posedge clk);
        m_q = 8'hF1; m_armed = 1'b0;
        #1;
        check_outputs("R1 reset value");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        cyc(1, 0, 8'h00, 0, 0, 0, "R2 read reset");
        cyc(0, 0, 8'h00, 0, 0, 0, "R2 rdata zero unselected");
        cyc(0, 1, 8'h00, 0, 0, 0, "R12 strobe without select");
        // First write clears bit 0 and arms the lock.
        cyc(1, 1, 8'h2C, 0, 0, 0, "R6 first write arms");
        cyc(1, 1, 8'h01, 0, 0, 0, "R6 second write blocked");
        cyc(1, 1, 8'h01, 0, 0, 1, "R7 special sets");
        cyc(1, 1, 8'h00, 1, 0, 1, "R8 no clear in scm");
        cyc(1, 1, 8'h8E, 1, 1, 1, "R11 mixed blocked write");
        cyc(1, 0, 8'h00, 1, 0, 0, "R5 readback while forced");
        cyc(1, 1, 8'h0F, 0, 0, 1, "R10 fast wake");
        cyc(1, 1, 8'hFF, 0, 1, 0, "R4 pll locked");
        do_reset();
        cyc(1, 1, 8'h00, 1, 0, 0, "R8 first write no clear");
        cyc(1, 1, 8'h00, 0, 0, 0, "R6 locked after first");
        for (int i = 0; i < 600; i++) begin
            cyc(($urandom % 4) != 0, ($urandom % 5) < 3, 8'($urandom),
                ($urandom % 4) == 0, ($urandom % 10) < 3, ($urandom % 10) < 3,
                "R2 random readback");
            if (i == 300) do_reset();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule